// File: doc/BRIEF.md
# Virtual-8086 Event Class Router

This block sits in the event path of a core that is executing 16-bit code under virtual-8086 emulation. When an event arrives (an exception, a non-maskable interrupt, a maskable hardware interrupt, or a software interrupt instruction with its vector), the router sorts it into one of three delivery classes. It then picks a delivery path: entry to the protected-mode handler, a general-protection fault, or internal redirection through the real-mode vector table.

For every entry into protected mode, the block also supplies the modified flags word and the strobes that zero the data segment registers and raise the privilege level to 0. The next stage performs the table walks and stack writes. Maskable interrupts that use virtual interrupt handling are tagged so that the next stage knows to test the virtual interrupt flag. When that flag is clear, the block marks the event as deferrable.

The decision is registered. It is presented one cycle after the event strobe and held steady until the consumer acknowledges it.

Top module: `v86_event_router`

## Requirements
- R1: An event strobe taken while no decision is pending makes `decValid` rise one clock later. While `decAck` is low, `decValid` and every decision output hold steady. A cycle with `decValid` and `decAck` both high clears `decValid` on the next clock.
- R2: An event strobe that arrives while a decision is pending is ignored. The held decision is unchanged, and no further decision appears once it is acknowledged.
- R3: Event types 0 (exception), 1 (NMI) and 4 to 7 (unknown) give class code 1 with delivery code 0 (protected-mode entry). Type 2 (maskable interrupt) with `cr4Vme` = 0 gives the same result.
- R4: Type 2 with `cr4Vme` = 1 gives class code 2, delivery code 0 and `vifTest` = 1. `deferrable` equals the inverse of `eflagsIn` bit 19. For all other classes, `vifTest` and `deferrable` are 0.
- R5: Type 3 (software INT n) gives class code 3. If the privilege field `eflagsIn[13:12]` equals 3, the delivery code is 0.
- R6: Type 3 with a privilege field below 3, `cr4Vme` = 1 and `redirBit` = 1 gives delivery code 2 (redirect). In that case `eflagsOut` equals `eflagsIn`, `segClear` is 0 and `cpl0` is 0.
- R7: Type 3 with a privilege field below 3 that does not meet the conditions in R6 gives delivery code 1 (#GP).
- R8: For delivery codes 0 and 1, `eflagsOut` is `eflagsIn` with bits 8, 14, 16 and 17 cleared. In the same case, `segClear` = 4'b1111 and `cpl0` = 1.
- R9: After reset, and after an acknowledge, every output is zero.
- R10: `vectorOut` carries the vector that was presented with the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Event strobe |
| evType | input | 3 | Event type code |
| evVector | input | 8 | Interrupt vector |
| cr4Vme | input | 1 | Virtual-mode extensions enable |
| redirBit | input | 1 | Redirection-map bit for this vector |
| eflagsIn | input | 32 | Flags word at the time of the event |
| decAck | input | 1 | Consumer acknowledge |
| decValid | output | 1 | Decision pending |
| classCode | output | 2 | Class 1, 2 or 3 |
| delivery | output | 2 | 0 protected-mode entry, 1 #GP, 2 redirect |
| deferrable | output | 1 | Class 2 event with the virtual interrupt flag clear |
| vifTest | output | 1 | Class 2 tag |
| eflagsOut | output | 32 | Flags for the delivery path |
| segClear | output | 4 | Zero strobes for DS, ES, FS, GS |
| cpl0 | output | 1 | Switch to privilege 0 |
| vectorOut | output | 8 | Captured vector |

## Verification
Every decision output becomes valid exactly one clock after the event strobe is sampled, because each output passes through a single register. The bench therefore records the cycle of each strobe and requires the result at the first falling edge after the next rising edge. After an acknowledge, the outputs drop one clock later, so the next event is driven only once `decValid` has been seen low. The hold test leaves the decision unacknowledged for several cycles and sends a competing strobe. It then checks the outputs at falling edges between those cycles.

// File: rtl/v86r_pkg.sv
package v86r_pkg;
  localparam int VEC_W  = 8;
  localparam int FLAG_W = 32;
  localparam int SEG_N  = 4;
  localparam int TYPE_W = 3;

  localparam int TF_BIT  = 8;
  localparam int NT_BIT  = 14;
  localparam int RF_BIT  = 16;
  localparam int VM_BIT  = 17;
  localparam int VIF_BIT = 19;
  localparam int IOPL_LO = 12;

  localparam logic [FLAG_W-1:0] ENTRY_MASK =
    (FLAG_W'(1) << TF_BIT) | (FLAG_W'(1) << NT_BIT) |
    (FLAG_W'(1) << RF_BIT) | (FLAG_W'(1) << VM_BIT);

  typedef enum logic [TYPE_W-1:0] {
    EV_EXC = 3'd0, EV_NMI = 3'd1, EV_MASKABLE = 3'd2, EV_SOFT = 3'd3
  } evKind_t;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0, CLS_ONE = 2'd1, CLS_TWO = 2'd2, CLS_THREE = 2'd3
  } evClass_t;

  typedef enum logic [1:0] {
    DLV_PMODE = 2'd0, DLV_GP = 2'd1, DLV_REDIR = 2'd2
  } delivery_t;

  typedef struct packed {
    logic      load;
    logic      clear;
    evClass_t  cls;
    delivery_t dlv;
    logic      entry;
    logic      tag;
  } ctrlStrobes_t;
endpackage

// File: rtl/v86r_ctrl.sv
module v86r_ctrl
  import v86r_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                evValid,
  input  logic [TYPE_W-1:0]   evType,
  input  logic                cr4Vme,
  input  logic                redirBit,
  input  logic [1:0]          iopl,
  input  logic                decAck,
  output ctrlStrobes_t        strobes,
  output logic                decValid
);
  logic accept;
  evClass_t clsNext;
  delivery_t dlvNext;

  assign accept = evValid && !decValid;

  always_comb begin
    clsNext = CLS_ONE;
    dlvNext = DLV_PMODE;
    case (evType)
      EV_MASKABLE: clsNext = cr4Vme ? CLS_TWO : CLS_ONE;
      EV_SOFT: begin
        clsNext = CLS_THREE;
        if (iopl == 2'd3)              dlvNext = DLV_PMODE;
        else if (cr4Vme && redirBit)   dlvNext = DLV_REDIR;
        else                           dlvNext = DLV_GP;
      end
      default: clsNext = CLS_ONE;
    endcase
  end

  always_comb begin
    strobes.load  = accept;
    strobes.clear = decValid && decAck;
    strobes.cls   = clsNext;
    strobes.dlv   = dlvNext;
    strobes.entry = (dlvNext != DLV_REDIR);
    strobes.tag   = (clsNext == CLS_TWO);
  end

  always_ff @(posedge clk) begin
    if (!rstN)               decValid <= 1'b0;
    else if (accept)         decValid <= 1'b1;
    else if (strobes.clear)  decValid <= 1'b0;
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !decValid) |=> decValid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decAck) |=> decValid);
  a_r1_release: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decAck) |=> !decValid);
  a_r2_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> !strobes.load);
endmodule

// File: rtl/v86r_datapath.sv
module v86r_datapath
  import v86r_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [VEC_W-1:0]    evVector,
  input  logic [FLAG_W-1:0]   eflagsIn,
  output logic [1:0]          classCode,
  output logic [1:0]          delivery,
  output logic                deferrable,
  output logic                vifTest,
  output logic [FLAG_W-1:0]   eflagsOut,
  output logic [SEG_N-1:0]    segClear,
  output logic                cpl0,
  output logic [VEC_W-1:0]    vectorOut
);
  evClass_t          classQ;
  delivery_t         dlvQ;
  logic              deferQ, tagQ, entryQ;
  logic [FLAG_W-1:0] flagsQ;
  logic [VEC_W-1:0]  vecQ;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      classQ <= CLS_NONE;
      dlvQ   <= DLV_PMODE;
      deferQ <= 1'b0;
      tagQ   <= 1'b0;
      entryQ <= 1'b0;
      flagsQ <= '0;
      vecQ   <= '0;
    end else if (strobes.load) begin
      classQ <= strobes.cls;
      dlvQ   <= strobes.dlv;
      tagQ   <= strobes.tag;
      deferQ <= strobes.tag && !eflagsIn[VIF_BIT];
      entryQ <= strobes.entry;
      flagsQ <= strobes.entry ? (eflagsIn & ~ENTRY_MASK) : eflagsIn;
      vecQ   <= evVector;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SEG_N; s++) begin : g_seg
      assign segClear[s] = entryQ;
    end
  endgenerate

  assign classCode  = classQ;
  assign delivery   = dlvQ;
  assign deferrable = deferQ;
  assign vifTest    = tagQ;
  assign eflagsOut  = flagsQ;
  assign cpl0       = entryQ;
  assign vectorOut  = vecQ;

  a_r1_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.clear) |=> ($stable(classQ) && $stable(flagsQ) && $stable(vecQ)));
  a_r6_redir_class: assert property (@(posedge clk) disable iff (!rstN)
    (dlvQ == DLV_REDIR) |-> (classQ == CLS_THREE && !entryQ));
  a_r4_defer_tag: assert property (@(posedge clk) disable iff (!rstN)
    deferQ |-> (tagQ && classQ == CLS_TWO));
  a_r8_vm_cleared: assert property (@(posedge clk) disable iff (!rstN)
    entryQ |-> (!flagsQ[VM_BIT] && !flagsQ[TF_BIT]));
endmodule

// File: rtl/v86_event_router.sv
module v86_event_router
  import v86r_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               evValid,
  input  logic [2:0]         evType,
  input  logic [7:0]         evVector,
  input  logic               cr4Vme,
  input  logic               redirBit,
  input  logic [31:0]        eflagsIn,
  input  logic               decAck,
  output logic               decValid,
  output logic [1:0]         classCode,
  output logic [1:0]         delivery,
  output logic               deferrable,
  output logic               vifTest,
  output logic [31:0]        eflagsOut,
  output logic [3:0]         segClear,
  output logic               cpl0,
  output logic [7:0]         vectorOut
);
  ctrlStrobes_t strobes;

  v86r_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evType(evType),
    .cr4Vme(cr4Vme), .redirBit(redirBit),
    .iopl(eflagsIn[IOPL_LO+1:IOPL_LO]), .decAck(decAck),
    .strobes(strobes), .decValid(decValid)
  );

  v86r_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evVector(evVector),
    .eflagsIn(eflagsIn), .classCode(classCode), .delivery(delivery),
    .deferrable(deferrable), .vifTest(vifTest), .eflagsOut(eflagsOut),
    .segClear(segClear), .cpl0(cpl0), .vectorOut(vectorOut)
  );

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (classCode == 2'd0 && segClear == 4'd0 && !cpl0));
endmodule

// File: tb/tb_v86_event_router.sv
module tb_v86_event_router;
  logic clk = 0, rstN = 0, evValid = 0, cr4Vme = 0, redirBit = 0, decAck = 0;
  logic [2:0] evType = 0;
  logic [7:0] evVector = 0;
  logic [31:0] eflagsIn = 0;
  logic decValid, deferrable, vifTest, cpl0;
  logic [1:0] classCode, delivery;
  logic [31:0] eflagsOut;
  logic [3:0] segClear;
  logic [7:0] vectorOut;

  always #5 clk = ~clk;

  v86_event_router dut (.*);

  typedef struct {
    logic [1:0] cls; logic [1:0] dlv; logic dfr; logic tag;
    logic [31:0] fl; logic [3:0] seg; logic c0; logic [7:0] vec;
    int cyc; string req;
  } exp_t;

  exp_t sb[$];
  int vectors = 0, fails = 0, cyc = 0;
  bit autoAck = 1, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(logic [2:0] t, logic vme, logic rb, logic [31:0] f, logic [7:0] v);
    exp_t e;
    logic entry;
    e.vec = v; e.tag = 0; e.dfr = 0; e.dlv = 2'd0; e.cls = 2'd1; e.req = "R3";
    if (t == 3'd2 && vme) begin
      e.cls = 2'd2; e.tag = 1; e.dfr = ~f[19]; e.req = "R4";
    end else if (t == 3'd3) begin
      e.cls = 2'd3;
      if (f[13:12] == 2'd3) begin e.dlv = 2'd0; e.req = "R5"; end
      else if (vme && rb) begin e.dlv = 2'd2; e.req = "R6"; end
      else begin e.dlv = 2'd1; e.req = "R7"; end
    end
    entry = (e.dlv != 2'd2);
    e.fl = entry ? (f & ~32'h0003_4100) : f;
    e.seg = entry ? 4'hF : 4'h0;
    e.c0 = entry;
    return e;
  endfunction

  task automatic send(logic [2:0] t, logic vme, logic rb, logic [31:0] f, logic [7:0] v);
    exp_t e;
    do @(negedge clk); while (decValid || sb.size() != 0);
    evValid = 1; evType = t; cr4Vme = vme; redirBit = rb; eflagsIn = f; evVector = v;
    e = model(t, vme, rb, f, v);
    e.cyc = cyc + 1;
    sb.push_back(e);
    @(negedge clk);
    evValid = 0;
  endtask

  task automatic compare(exp_t e);
    chk(classCode == e.cls, e.req, "class", classCode, e.cls);
    chk(delivery == e.dlv, e.req, "delivery", delivery, e.dlv);
    chk(deferrable == e.dfr && vifTest == e.tag, "R4", "defer/tag", {deferrable, vifTest}, {e.dfr, e.tag});
    chk(eflagsOut == e.fl, "R8", "eflagsOut", eflagsOut, e.fl);
    chk(segClear == e.seg && cpl0 == e.c0, "R8", "seg/cpl0", {segClear, cpl0}, {e.seg, e.c0});
    chk(vectorOut == e.vec, "R10", "vector", vectorOut, e.vec);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      decAck = 0;
      if (autoAck && rstN && sb.size() != 0) begin
        if (cyc == sb[0].cyc) begin
          chk(decValid, "R1", "decValid latency", decValid, 1);
          e = sb.pop_front();
          compare(e);
          decAck = 1;
        end else if (cyc > sb[0].cyc) begin
          chk(0, "R1", "decision missing", decValid, 1);
          void'(sb.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin : driver
    exp_t e;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!decValid && classCode == 0 && delivery == 0 && eflagsOut == 0 && segClear == 0
        && !cpl0 && vectorOut == 0 && !vifTest && !deferrable, "R9", "reset outputs",
        {decValid, classCode, segClear}, 0);
    rstN = 1;
    @(negedge clk);
    // R3 class 1 types
    send(3'd0, 1, 1, 32'h0002_3302, 8'h0D);
    send(3'd1, 1, 0, 32'hFFFF_FFFF, 8'h02);
    send(3'd4, 0, 0, 32'h0002_0000, 8'h11);
    send(3'd7, 1, 1, 32'h0002_4100, 8'h77);
    send(3'd2, 0, 0, 32'h0002_0200, 8'h08);
    // R4 class 2, VIF set and clear
    send(3'd2, 1, 0, 32'h000A_0200, 8'h09);
    send(3'd2, 1, 1, 32'h0002_0200, 8'h0A);
    // R5 INT n with privilege 3
    send(3'd3, 1, 1, 32'h0002_3000, 8'h21);
    // R6 redirect
    send(3'd3, 1, 1, 32'h0002_1100, 8'h21);
    // R7 #GP
    send(3'd3, 1, 0, 32'h0002_2000, 8'h10);
    send(3'd3, 0, 1, 32'h0002_0000, 8'h13);
    for (int i = 0; i < 60; i++)
      send(3'($urandom), 1'($urandom), 1'($urandom), $urandom, 8'($urandom));
    do @(negedge clk); while (sb.size() != 0 || decValid);
    // R1/R2 hold and ignore
    autoAck = 0;
    @(negedge clk);
    evValid = 1; evType = 3'd3; cr4Vme = 1; redirBit = 1; eflagsIn = 32'h0002_0000; evVector = 8'h33;
    e = model(3'd3, 1, 1, 32'h0002_0000, 8'h33);
    @(negedge clk);
    evValid = 0;
    chk(decValid, "R1", "valid after strobe", decValid, 1);
    compare(e);
    repeat (3) @(negedge clk);
    chk(decValid, "R1", "valid held", decValid, 1);
    compare(e);
    evValid = 1; evType = 3'd0; eflagsIn = 32'h0002_3000; evVector = 8'hEE;
    @(negedge clk);
    evValid = 0;
    chk(decValid, "R2", "still pending", decValid, 1);
    chk(vectorOut == 8'h33 && delivery == 2'd2, "R2", "held decision", {vectorOut, delivery}, {8'h33, 2'd2});
    decAck = 1;
    @(negedge clk);
    decAck = 0;
    chk(!decValid, "R1", "released after ack", decValid, 0);
    chk(classCode == 0 && segClear == 0 && eflagsOut == 0 && vectorOut == 0, "R9", "cleared after ack",
        {classCode, vectorOut}, 0);
    repeat (2) @(negedge clk);
    chk(!decValid, "R2", "no late decision", decValid, 0);
    done = 1;
    finish_run();
  end
endmodule